// File: doc/BRIEF.md
# Burst Line Bus Sequencer

This block sits between a cache controller and an external memory bus whose data path is 64 bits wide. The core behind the cache works with 32-bit registers. On the cache side it takes one request at a time. A request carries an operation kind, an address, a byte-enable mask and, for writes, a whole line of write data. The block then runs exactly one bus cycle and answers with a one-cycle completion pulse. For reads, that pulse comes with the returned data.

There are four kinds of cycle. A single read and a single write each move one 64-bit word under a byte-enable mask, so they transfer at most eight bytes. A burst read (a line fill) and a burst write (a line write-back) each move a 32-byte line as four consecutive 64-bit beats. A burst uses one address phase, and every cache-line transfer is a burst. On the bus side, each cycle opens with a one-cycle address strobe. A data phase follows, in which the slave accepts or delivers a beat on every clock where it raises ready. Without ready, the bus is held in wait states.

Top module: `line_bus_seq`

## Requirements
- R1: After reset, `bus_ads`, `bus_cyc` and `done` are 0.
- R2: A single read (`req_kind` = 2'b00) produces one address phase with `bus_addr` equal to `req_addr` with its low 3 bits cleared, `bus_we` = 0, `bus_burst` = 0 and `bus_be` = `req_be`. The first beat accepted with `bus_rdy` returns its `bus_rdata` on `rdata[63:0]`.
- R3: A single write (`req_kind` = 2'b01) drives `bus_we` = 1, `bus_be` = `req_be` and `bus_wdata` = `req_wdata[63:0]` throughout its one-beat data phase.
- R4: A burst (`req_kind[1]` = 1) drives `bus_addr` = `req_addr` with its low 5 bits cleared, `bus_burst` = 1 and `bus_be` = 8'hFF for the whole cycle.
- R5: A burst read (`req_kind` = 2'b10) accepts exactly four beats. Beat k (k = 0..3) is returned on `rdata[64k+63:64k]`.
- R6: A burst write (`req_kind` = 2'b11) presents word k of `req_wdata` (bits 64k+63:64k) on `bus_wdata` during beat k.
- R7: In the data phase, a clock without `bus_rdy` is a wait state. It neither advances the beat nor changes `bus_wdata`, and it does not end the cycle.
- R8: `done` is high for exactly one clock. That clock follows the edge at which the final beat is accepted, and `done` is 0 at all other times.
- R9: A request presented while a cycle is in progress is ignored. It produces no address strobe, it does not change `bus_addr` or `bus_we`, and it is not remembered for later.
- R10: `bus_ads` is high for exactly the one clock after the edge that accepts a request. `bus_cyc` is high from that clock until the final beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Cache request strobe, sampled while idle |
| req_kind | input | 2 | bit1 = burst, bit0 = write |
| req_addr | input | 32 | Byte address of the request |
| req_be | input | 8 | Byte enables for single cycles |
| req_wdata | input | 256 | Write line; a single write uses bits 63:0 |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 256 | Read line; a single read fills bits 63:0 |
| bus_ads | output | 1 | Address strobe |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_addr | output | 32 | Aligned bus address |
| bus_we | output | 1 | Write cycle |
| bus_burst | output | 1 | Four-beat burst cycle |
| bus_be | output | 8 | Byte-lane enables |
| bus_wdata | output | 64 | Write data for the current beat |
| bus_rdata | input | 64 | Read data from the slave |
| bus_rdy | input | 1 | Slave accepts or delivers the current beat |

## Verification
On every clock, the assertions check the following: the address strobe lasts one clock and never starts while a cycle is running; the beat counter and write data stay frozen across wait states; burst addresses are line-aligned with all lanes enabled; and the completion pulse lasts one clock and follows an accepted final beat. Some behaviour only the bench's scenarios can show. These are that each beat's data lands in the correct word of the read line, that the correct write word appears on each beat, that single cycles carry the caller's byte mask, and that a request raised mid-cycle leaves no trace once the cycle ends.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } lbs_state_e;

  typedef struct packed {
    logic burst;
    logic write;
  } lbs_kind_t;

endpackage

// File: rtl/lbs_ctrl.sv
module lbs_ctrl
  import lbs_pkg::*;
#(
  parameter int BEATS = 4,
  localparam int CNT_W = $clog2(BEATS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_burst,
  input  logic             rdy,
  output logic             accept,
  output logic             fire,
  output logic             last_beat,
  output logic             hold,
  output logic [CNT_W-1:0] beat,
  output logic             ads,
  output logic             cyc,
  output logic             done
);

  lbs_state_e st;
  logic       burst_q;

  assign accept    = (st == ST_IDLE) && req_valid;
  assign fire      = (st == ST_DATA) && rdy;
  assign hold      = (st == ST_DATA) && !rdy;
  assign last_beat = !burst_q || (beat == CNT_W'(BEATS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      burst_q <= 1'b0;
      beat    <= '0;
      ads     <= 1'b0;
      cyc     <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            st      <= ST_ADDR;
            burst_q <= req_burst;
            beat    <= '0;
            ads     <= 1'b1;
            cyc     <= 1'b1;
          end
        end
        ST_ADDR: begin
          st  <= ST_DATA;
          ads <= 1'b0;
        end
        ST_DATA: begin
          if (rdy) begin
            if (last_beat) begin
              st   <= ST_IDLE;
              beat <= '0;
              cyc  <= 1'b0;
              done <= 1'b1;
            end else begin
              beat <= beat + CNT_W'(1);
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10: strobe lasts one clock and follows an accepted request
  a_r10_ads_one_clock: assert property (@(posedge clk) disable iff (rst)
    ads |=> !ads);
  a_r10_ads_after_accept: assert property (@(posedge clk) disable iff (rst)
    ads |-> $past(accept));
  // R9: no new strobe while a cycle runs
  a_r9_no_ads_when_busy: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |=> !ads);
  // R7: wait state freezes the beat counter
  a_r7_beat_hold: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(beat) && cyc);
  // R8: completion pulse
  a_r8_done_one_clock: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_done_after_last: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(fire && last_beat));
  // R2: a single cycle never leaves beat 0
  a_r2_single_one_beat: assert property (@(posedge clk) disable iff (rst)
    (cyc && !burst_q) |-> (beat == '0));

endmodule

// File: rtl/lbs_wbuf.sv
module lbs_wbuf #(
  parameter int DATA_W = 64,
  parameter int BEATS  = 4,
  localparam int CNT_W  = $clog2(BEATS),
  localparam int LINE_W = DATA_W * BEATS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [LINE_W-1:0] line_in,
  input  logic              fire,
  input  logic              last_beat,
  input  logic              hold,
  input  logic [CNT_W-1:0]  beat,
  output logic [DATA_W-1:0] wdata
);

  logic [DATA_W-1:0] mem [BEATS];
  logic [CNT_W-1:0]  beat_nxt;

  assign beat_nxt = beat + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (load) begin
      for (int k = 0; k < BEATS; k++) begin
        mem[k] <= line_in[k*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wdata <= '0;
    end else if (load) begin
      wdata <= line_in[DATA_W-1:0];
    end else if (fire && !last_beat) begin
      wdata <= mem[beat_nxt];
    end
  end

  // R7: write data frozen across a wait state
  a_r7_wdata_hold: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(wdata));

endmodule

// File: rtl/lbs_rbuf.sv
module lbs_rbuf #(
  parameter int DATA_W = 64,
  parameter int BEATS  = 4,
  localparam int CNT_W  = $clog2(BEATS),
  localparam int LINE_W = DATA_W * BEATS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [CNT_W-1:0]  beat,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [LINE_W-1:0] line_out
);

  logic [DATA_W-1:0] words [BEATS];

  for (genvar k = 0; k < BEATS; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        words[k] <= '0;
      end else if (fire && (beat == CNT_W'(k))) begin
        words[k] <= bus_rdata;
      end
    end
    assign line_out[k*DATA_W +: DATA_W] = words[k];
  end

  // R5: the read line only changes on an accepted beat
  a_r5_line_stable: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(line_out));

endmodule

// File: rtl/line_bus_seq.sv
module line_bus_seq
  import lbs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int BEATS  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic [1:0]               req_kind,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W/8-1:0]      req_be,
  input  logic [DATA_W*BEATS-1:0]  req_wdata,
  output logic                     done,
  output logic [DATA_W*BEATS-1:0]  rdata,
  output logic                     bus_ads,
  output logic                     bus_cyc,
  output logic [ADDR_W-1:0]        bus_addr,
  output logic                     bus_we,
  output logic                     bus_burst,
  output logic [DATA_W/8-1:0]      bus_be,
  output logic [DATA_W-1:0]        bus_wdata,
  input  logic [DATA_W-1:0]        bus_rdata,
  input  logic                     bus_rdy
);

  localparam int BE_W      = DATA_W / 8;
  localparam int CNT_W     = $clog2(BEATS);
  localparam int WORD_OFFS = $clog2(BE_W);
  localparam int LINE_OFFS = $clog2(BE_W * BEATS);
  localparam logic [ADDR_W-1:0] WORD_MASK = {{(ADDR_W-WORD_OFFS){1'b1}}, {WORD_OFFS{1'b0}}};
  localparam logic [ADDR_W-1:0] LINE_MASK = {{(ADDR_W-LINE_OFFS){1'b1}}, {LINE_OFFS{1'b0}}};

  lbs_kind_t        kind;
  logic             accept;
  logic             fire;
  logic             last_beat;
  logic             hold;
  logic [CNT_W-1:0] beat;

  assign kind = lbs_kind_t'(req_kind);

  lbs_ctrl #(.BEATS(BEATS)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_burst (kind.burst),
    .rdy       (bus_rdy),
    .accept    (accept),
    .fire      (fire),
    .last_beat (last_beat),
    .hold      (hold),
    .beat      (beat),
    .ads       (bus_ads),
    .cyc       (bus_cyc),
    .done      (done)
  );

  lbs_wbuf #(.DATA_W(DATA_W), .BEATS(BEATS)) wbuf_i (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .line_in   (req_wdata),
    .fire      (fire),
    .last_beat (last_beat),
    .hold      (hold),
    .beat      (beat),
    .wdata     (bus_wdata)
  );

  lbs_rbuf #(.DATA_W(DATA_W), .BEATS(BEATS)) rbuf_i (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .beat      (beat),
    .bus_rdata (bus_rdata),
    .line_out  (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr  <= '0;
      bus_we    <= 1'b0;
      bus_burst <= 1'b0;
      bus_be    <= '0;
    end else if (accept) begin
      bus_addr  <= req_addr & (kind.burst ? LINE_MASK : WORD_MASK);
      bus_we    <= kind.write;
      bus_burst <= kind.burst;
      bus_be    <= kind.burst ? {BE_W{1'b1}} : req_be;
    end
  end

  // R4: burst address line-aligned, all lanes on
  a_r4_burst_aligned: assert property (@(posedge clk) disable iff (rst)
    (bus_ads && bus_burst) |-> (bus_addr[LINE_OFFS-1:0] == '0));
  a_r4_burst_all_lanes: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && bus_burst) |-> (&bus_be));
  // R2: single address word-aligned
  a_r2_single_aligned: assert property (@(posedge clk) disable iff (rst)
    (bus_ads && !bus_burst) |-> (bus_addr[WORD_OFFS-1:0] == '0));
  // R9: cycle attributes frozen while the cycle runs
  a_r9_attr_stable: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && !bus_ads) |-> $stable(bus_addr) && $stable(bus_we) && $stable(bus_burst));

endmodule

// File: tb/line_bus_seq_tb_top.sv
module line_bus_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int VEC_W = 50;
  localparam int NVEC  = 6;
  // {kind[1:0], addr[31:0], be[7:0], waits[7:0]}; waits holds 2 bits per beat
  localparam logic [VEC_W-1:0] VECS [NVEC] = '{
    {2'b00, 32'h0000_1234, 8'h0F, 8'h00},
    {2'b01, 32'h0000_2007, 8'hF0, 8'h02},
    {2'b10, 32'h8000_005F, 8'h11, 8'h00},
    {2'b11, 32'h0001_0023, 8'h00, 8'b01_00_11_00},
    {2'b10, 32'hFFFF_FFFF, 8'h00, 8'b10_01_00_11},
    {2'b01, 32'h0000_0008, 8'h01, 8'h01}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic [1:0]   req_kind = '0;
  logic [31:0]  req_addr = '0;
  logic [7:0]   req_be = '0;
  logic [255:0] req_wdata = '0;
  logic         done;
  logic [255:0] rdata;
  logic         bus_ads, bus_cyc, bus_we, bus_burst;
  logic [31:0]  bus_addr;
  logic [7:0]   bus_be;
  logic [63:0]  bus_wdata;
  logic [63:0]  bus_rdata = '0;
  logic         bus_rdy = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_bus_seq dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .done(done), .rdata(rdata), .bus_ads(bus_ads), .bus_cyc(bus_cyc),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_burst(bus_burst),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdy(bus_rdy)
  );

  function automatic logic [63:0] wword(input logic [31:0] a, input int k);
    return {~a, 32'hBEEF_0000 + 32'(k)};
  endfunction

  function automatic logic [63:0] rword(input logic [31:0] a, input int k);
    return {a, 32'hD00D_0000 + 32'(k)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL R8 watchdog: done actual 0 expected 1");
      summary();
      $finish;
    end
  end

  task automatic do_cycle(input logic [1:0] kind, input logic [31:0] addr,
                          input logic [7:0] be, input logic [7:0] waits,
                          input bit noise);
    bit burst = kind[1];
    bit wr = kind[0];
    int nb = burst ? 4 : 1;
    logic [31:0] exp_addr = addr & (burst ? 32'hFFFF_FFE0 : 32'hFFFF_FFF8);
    logic [7:0] exp_be = burst ? 8'hFF : be;
    logic [255:0] line;
    for (int k = 0; k < 4; k++) line[k*64 +: 64] = wword(addr, k);
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_addr = addr; req_be = be; req_wdata = line;
    @(negedge clk);
    req_valid = 1'b0;
    // address phase
    chk(bus_ads === 1'b1, "R10 ads", 64'(bus_ads), 64'd1);
    chk(bus_cyc === 1'b1, "R10 cyc", 64'(bus_cyc), 64'd1);
    chk(bus_addr === exp_addr, burst ? "R4 addr" : "R2 addr", 64'(bus_addr), 64'(exp_addr));
    chk(bus_be === exp_be, burst ? "R4 be" : "R2 be", 64'(bus_be), 64'(exp_be));
    chk(bus_burst === burst, "R4 burst flag", 64'(bus_burst), 64'(burst));
    chk(bus_we === wr, "R3 we", 64'(bus_we), 64'(wr));
    @(negedge clk);
    if (noise) begin
      req_valid = 1'b1; req_kind = ~kind; req_addr = ~addr; req_be = ~be;
    end
    for (int k = 0; k < nb; k++) begin
      int nw = int'(waits[2*k +: 2]);
      for (int w = 0; w < nw; w++) begin
        bus_rdy = 1'b0;
        bus_rdata = 64'hDEAD_DEAD_DEAD_DEAD;
        if (wr) chk(bus_wdata === wword(addr, k), "R7 wdata in wait", bus_wdata, wword(addr, k));
        chk(done === 1'b0, "R8 early done", 64'(done), 64'd0);
        @(negedge clk);
        chk(bus_cyc === 1'b1, "R7 wait keeps cycle", 64'(bus_cyc), 64'd1);
      end
      chk(bus_ads === 1'b0, "R9 no ads", 64'(bus_ads), 64'd0);
      chk(bus_addr === exp_addr, "R9 addr held", 64'(bus_addr), 64'(exp_addr));
      chk(bus_we === wr, "R9 we held", 64'(bus_we), 64'(wr));
      chk(done === 1'b0, "R8 early done", 64'(done), 64'd0);
      if (wr) chk(bus_wdata === wword(addr, k), burst ? "R6 beat wdata" : "R3 wdata",
                  bus_wdata, wword(addr, k));
      bus_rdy = 1'b1;
      bus_rdata = rword(addr, k);
      if (k == nb - 1) req_valid = 1'b0;
      @(negedge clk);
    end
    bus_rdy = 1'b0;
    chk(done === 1'b1, "R8 done", 64'(done), 64'd1);
    chk(bus_cyc === 1'b0, "R10 cyc end", 64'(bus_cyc), 64'd0);
    if (!wr) begin
      for (int k = 0; k < nb; k++)
        chk(rdata[k*64 +: 64] === rword(addr, k), burst ? "R5 rdata word" : "R2 rdata",
            rdata[k*64 +: 64], rword(addr, k));
    end
    @(negedge clk);
    chk(done === 1'b0, "R8 done pulse", 64'(done), 64'd0);
    chk(bus_cyc === 1'b0 && bus_ads === 1'b0, "R9 nothing pending",
        64'({bus_cyc, bus_ads}), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(bus_ads === 1'b0, "R1 ads", 64'(bus_ads), 64'd0);
    chk(bus_cyc === 1'b0, "R1 cyc", 64'(bus_cyc), 64'd0);
    chk(done === 1'b0, "R1 done", 64'(done), 64'd0);
    for (int i = 0; i < NVEC; i++) begin
      do_cycle(VECS[i][49:48], VECS[i][47:16], VECS[i][15:8], VECS[i][7:0], 1'b0);
    end
    // R9: requests raised mid-cycle on a burst write and a single read
    do_cycle(2'b11, 32'h0000_4440, 8'h00, 8'b00_01_10_00, 1'b1);
    do_cycle(2'b00, 32'h0000_0100, 8'h80, 8'h01, 1'b1);
    // R7: long waits on the last burst beat
    do_cycle(2'b11, 32'h1234_5660, 8'h00, 8'b11_00_00_00, 1'b0);
    // R1: reset in the middle of a burst
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'b10; req_addr = 32'h40;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(bus_cyc === 1'b0 && bus_ads === 1'b0 && done === 1'b0, "R1 mid-cycle reset",
        64'({bus_cyc, bus_ads, done}), 64'd0);
    do_cycle(2'b10, 32'h0000_0080, 8'h00, 8'h00, 1'b0);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule